// File: doc/BRIEF.md
# Interrupt Flag Set/Clear Register Bank

This block holds the interrupt state of a nonvolatile memory controller. It has two event flags, one for a finished erase and one for a finished program operation, and a mask bit for each flag. The erase and program engines each give a one-cycle done pulse, and that pulse raises the matching flag. Software sees the flags and the mask bits through two read-only registers. It can change either set of bits only through write-one-to-set and write-one-to-clear alias registers, so a single write never disturbs a bit that the write does not name.

A single level interrupt request goes to the system interrupt controller. It is registered, and it is high while any flag is set together with its mask bit. It stays high until software clears the flag or the mask bit. The bus is a simple synchronous 32-bit port with a 12-bit page offset, a write strobe and a read strobe. Read data is combinational and valid in the cycle that the read strobe is high.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, the status register, the enable register and `irqOut` are all 0.
- R2: A write to offset 0xFEC sets each status flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Bit 0 is the end-of-erase flag and bit 1 is the end-of-program flag.
- R3: A write to offset 0xFE8 clears each status flag whose data bit is 1 and leaves the other flags unchanged.
- R4: A write to offset 0xFDC sets each enable bit whose data bit is 1, with the same bit positions as the flags. The enable register reads at offset 0xFE4.
- R5: A write to offset 0xFD8 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R6: The status register reads at offset 0xFE0. Writes to offset 0xFE0 or 0xFE4 change neither the flags nor the enables.
- R7: Reads of 0xFEC, 0xFE8, 0xFDC, 0xFD8 and of any unmapped offset return 0. Bits 31:2 of every read are 0. Data bits 31:2 of any write have no effect. `busRdata` is 0 whenever `busRd` is low.
- R8: A one-cycle pulse on `eraseDone` sets flag bit 0, and a one-cycle pulse on `progDone` sets flag bit 1. The flag is readable in the cycle after the pulse.
- R9: If a done pulse and a clear write to the same flag fall in the same cycle, the flag ends up set. Other flags named in that clear write are still cleared.
- R10: `irqOut` is registered. In each cycle it equals the OR over both bits of (flag AND enable) as they were one cycle earlier, so a set flag with its enable bit at 0 never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 12 | Register offset within the page |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRd | input | 1 | Read strobe |
| busRdata | output | 32 | Read data, combinational |
| eraseDone | input | 1 | One-cycle end-of-erase pulse |
| progDone | input | 1 | One-cycle end-of-program pulse |
| irqOut | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that the set and clear aliases act only on the bits named in the write data, that a done pulse always leaves its flag set (including when a clear of that flag arrives in the same cycle), that the enables hold when no enable alias is written, that the request trails flag AND enable by exactly one cycle, and that reserved and idle read bits stay 0. Other behaviour shows only in the bench scenarios. These cover the exact values after reset, the read-back values at each offset, all-zero writes that leave the state unchanged, writes to the read-only offsets, and the masking sequences where a flag is pending while its enable is off, then is enabled, and then is cleared.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int unsigned NUM_EVT = 2;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 12;

  localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'hFD8;
  localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'hFDC;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 12'hFE0;
  localparam logic [ADDR_W-1:0] OFS_ENABLE   = 12'hFE4;
  localparam logic [ADDR_W-1:0] OFS_FLAG_CLR = 12'hFE8;
  localparam logic [ADDR_W-1:0] OFS_FLAG_SET = 12'hFEC;

  typedef struct packed {
    logic [NUM_EVT-1:0] flagSet;
    logic [NUM_EVT-1:0] flagClr;
    logic [NUM_EVT-1:0] enSet;
    logic [NUM_EVT-1:0] enClr;
  } regStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_ENABLE = 2'd2
  } rdSel_t;
endpackage

// File: rtl/irq_reg_ctrl.sv
module irq_reg_ctrl
  import irqbank_pkg::*;
(
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic [NUM_EVT-1:0] wrBits,
  input  logic               busRd,
  output regStrobe_t         strb,
  output rdSel_t             rdSel
);
  always_comb begin
    strb = '0;
    if (busWr) begin
      unique case (busAddr)
        OFS_FLAG_SET: strb.flagSet = wrBits;
        OFS_FLAG_CLR: strb.flagClr = wrBits;
        OFS_EN_SET:   strb.enSet   = wrBits;
        OFS_EN_CLR:   strb.enClr   = wrBits;
        default:      strb         = '0;
      endcase
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (busRd) begin
      unique case (busAddr)
        OFS_STATUS: rdSel = RD_STATUS;
        OFS_ENABLE: rdSel = RD_ENABLE;
        default:    rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_reg_dp.sv
module irq_reg_dp
  import irqbank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [NUM_EVT-1:0] hwEvt,
  input  rdSel_t             rdSel,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_EVT-1:0] flagQ,
  output logic [NUM_EVT-1:0] enQ,
  output logic               irqQ
);
  logic [NUM_EVT-1:0] flagD;
  logic [NUM_EVT-1:0] enD;

  // Hardware event outranks a software clear of the same bit.
  assign flagD = (flagQ | strb.flagSet | hwEvt) & ~(strb.flagClr & ~hwEvt);
  assign enD   = (enQ | strb.enSet) & ~strb.enClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      irqQ  <= 1'b0;
    end else begin
      flagQ <= flagD;
      enQ   <= enD;
      irqQ  <= |(flagQ & enQ);
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_STATUS: rdData[NUM_EVT-1:0] = flagQ;
      RD_ENABLE: rdData[NUM_EVT-1:0] = enQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irqbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata,
  input  logic              eraseDone,
  input  logic              progDone,
  output logic              irqOut
);
  regStrobe_t         strb;
  rdSel_t             rdSel;
  logic [NUM_EVT-1:0] flagQ;
  logic [NUM_EVT-1:0] enQ;
  logic [NUM_EVT-1:0] hwEvt;

  assign hwEvt = {progDone, eraseDone};

  irq_reg_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .wrBits  (busWdata[NUM_EVT-1:0]),
    .busRd   (busRd),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  irq_reg_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .hwEvt  (hwEvt),
    .rdSel  (rdSel),
    .rdData (busRdata),
    .flagQ  (flagQ),
    .enQ    (enQ),
    .irqQ   (irqOut)
  );
endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk
  import irqbank_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busRd,
  input logic [DATA_W-1:0] busRdata,
  input logic              eraseDone,
  input logic              progDone,
  input logic              irqOut,
  input logic [1:0]        flagQ,
  input logic [1:0]        enQ
);
  AST_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_FLAG_SET) |=> ((flagQ & $past(busWdata[1:0])) == $past(busWdata[1:0]))); // R2
  AST_SW_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_FLAG_CLR && !eraseDone && !progDone) |=> ((flagQ & $past(busWdata[1:0])) == 2'b00)); // R3
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_EN_SET) |=> ((enQ & $past(busWdata[1:0])) == $past(busWdata[1:0]))); // R4
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_EN_CLR) |=> ((enQ & $past(busWdata[1:0])) == 2'b00)); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && (busAddr == OFS_EN_SET || busAddr == OFS_EN_CLR)) |=> $stable(enQ)); // R6
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdata == '0)); // R7
  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:2] == '0); // R7
  AST_ERASE_EVT: assert property (@(posedge clk) disable iff (!rstN)
    eraseDone |=> flagQ[0]); // R8
  AST_PROG_EVT: assert property (@(posedge clk) disable iff (!rstN)
    progDone |=> flagQ[1]); // R8
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_FLAG_CLR && busWdata[0] && eraseDone) |=> flagQ[0]); // R9
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(flagQ & enQ)))); // R10
endmodule

bind irq_flag_bank irq_flag_bank_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busWdata  (busWdata),
  .busRd     (busRd),
  .busRdata  (busRdata),
  .eraseDone (eraseDone),
  .progDone  (progDone),
  .irqOut    (irqOut),
  .flagQ     (flagQ),
  .enQ       (enQ)
);

// File: tb/tb_irq_flag_bank.sv
module tb_irq_flag_bank;
  import irqbank_pkg::*;

  localparam int unsigned MAX_CYCLES = 20000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWr = 1'b0;
  logic [DATA_W-1:0] busWdata = '0;
  logic              busRd = 1'b0;
  logic [DATA_W-1:0] busRdata;
  logic              eraseDone = 1'b0;
  logic              progDone = 1'b0;
  logic              irqOut;
  logic              chkIrq = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       req;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  irq_flag_bank dut (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busWdata  (busWdata),
    .busRd     (busRd),
    .busRdata  (busRdata),
    .eraseDone (eraseDone),
    .progDone  (progDone),
    .irqOut    (irqOut)
  );

  // Monitor: pops one expectation per marked negedge.
  always begin
    @(negedge clk);
    if (busRd || chkIrq) begin
      expItem_t it;
      logic [31:0] act;
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL monitor: no expectation queued (actual n/a, expected an item)");
      end else begin
        it = expQ.pop_front();
        act = it.isIrq ? {31'd0, irqOut} : busRdata;
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string req);
    @(posedge clk); #1;
    busRd = 1'b1; busAddr = a;
    expQ.push_back('{1'b0, e, req});
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic checkIrqNow(input logic e, input string req);
    chkIrq = 1'b1;
    expQ.push_back('{1'b1, {31'd0, e}, req});
    @(posedge clk); #1;
    chkIrq = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string req);
    @(posedge clk); #1;
    checkIrqNow(e, req);
  endtask

  task automatic pulse(input bit erase, input bit prog);
    @(posedge clk); #1;
    eraseDone = erase; progDone = prog;
    @(posedge clk); #1;
    eraseDone = 1'b0; progDone = 1'b0;
  endtask

  task automatic clrWithPulse(input logic [31:0] d, input bit erase, input bit prog);
    @(posedge clk); #1;
    busWr = 1'b1; busAddr = OFS_FLAG_CLR; busWdata = d;
    eraseDone = erase; progDone = prog;
    @(posedge clk); #1;
    busWr = 1'b0; busWdata = '0; eraseDone = 1'b0; progDone = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    doRead(OFS_STATUS, 32'h0, "R1 status");
    doRead(OFS_ENABLE, 32'h0, "R1 enable");
    checkIrq(1'b0, "R1 irq");

    // R2 flag set, all-zero write first
    doWrite(OFS_FLAG_SET, 32'h0);
    doRead(OFS_STATUS, 32'h0, "R2 zero write");
    doWrite(OFS_FLAG_SET, 32'h1);
    doRead(OFS_STATUS, 32'h1, "R2 erase flag");
    doWrite(OFS_FLAG_SET, 32'h2);
    doRead(OFS_STATUS, 32'h3, "R2 program flag");
    checkIrq(1'b0, "R10 masked by enables");

    // R3 flag clear
    doWrite(OFS_FLAG_CLR, 32'h0);
    doRead(OFS_STATUS, 32'h3, "R3 zero write");
    doWrite(OFS_FLAG_CLR, 32'h1);
    doRead(OFS_STATUS, 32'h2, "R3 clear erase");
    doWrite(OFS_FLAG_CLR, 32'h2);
    doRead(OFS_STATUS, 32'h0, "R3 clear program");

    // R4 / R10 enable set and masking
    doWrite(OFS_EN_SET, 32'h0);
    doRead(OFS_ENABLE, 32'h0, "R4 zero write");
    doWrite(OFS_EN_SET, 32'h2);
    doRead(OFS_ENABLE, 32'h2, "R4 set program enable");
    checkIrq(1'b0, "R10 no flags");
    doWrite(OFS_FLAG_SET, 32'h1);
    checkIrq(1'b0, "R10 erase flag masked");
    doWrite(OFS_FLAG_SET, 32'h2);
    checkIrqNow(1'b0, "R10 one-cycle lag");
    checkIrqNow(1'b1, "R10 irq raised");

    // R5 enable clear
    doWrite(OFS_EN_CLR, 32'h0);
    doRead(OFS_ENABLE, 32'h2, "R5 zero write");
    doWrite(OFS_EN_CLR, 32'h2);
    doRead(OFS_ENABLE, 32'h0, "R5 clear program enable");
    checkIrq(1'b0, "R10 irq dropped by enable");
    doWrite(OFS_EN_SET, 32'h3);
    doRead(OFS_ENABLE, 32'h3, "R4 set both");
    checkIrq(1'b1, "R10 both enabled");
    doWrite(OFS_FLAG_CLR, 32'h3);
    checkIrq(1'b0, "R10 irq dropped by clear");
    doWrite(OFS_EN_CLR, 32'h1);
    doRead(OFS_ENABLE, 32'h2, "R5 clear erase enable");
    doWrite(OFS_EN_CLR, 32'h3);
    doRead(OFS_ENABLE, 32'h0, "R5 clear both");

    // R6 read-only registers
    doWrite(OFS_STATUS, 32'h3);
    doRead(OFS_STATUS, 32'h0, "R6 status write ignored");
    doWrite(OFS_ENABLE, 32'h3);
    doRead(OFS_ENABLE, 32'h0, "R6 enable write ignored");

    // R7 reserved bits and write-only/unmapped reads
    doWrite(OFS_FLAG_SET, 32'hFFFF_FFFC);
    doRead(OFS_STATUS, 32'h0, "R7 reserved write ignored");
    doWrite(OFS_FLAG_SET, 32'hFFFF_FFFF);
    doRead(OFS_STATUS, 32'h3, "R7 reserved read zero");
    doWrite(OFS_EN_SET, 32'h3);
    doRead(OFS_FLAG_SET, 32'h0, "R7 flag-set read");
    doRead(OFS_FLAG_CLR, 32'h0, "R7 flag-clear read");
    doRead(OFS_EN_SET, 32'h0, "R7 enable-set read");
    doRead(OFS_EN_CLR, 32'h0, "R7 enable-clear read");
    doRead(12'h000, 32'h0, "R7 unmapped read");
    doWrite(OFS_FLAG_CLR, 32'h3);
    doWrite(OFS_EN_CLR, 32'h3);

    // R8 hardware events
    pulse(1'b1, 1'b0);
    doRead(OFS_STATUS, 32'h1, "R8 erase done");
    pulse(1'b0, 1'b1);
    doRead(OFS_STATUS, 32'h3, "R8 program done");

    // R9 hardware set beats software clear
    clrWithPulse(32'h1, 1'b1, 1'b0);
    doRead(OFS_STATUS, 32'h3, "R9 erase kept");
    clrWithPulse(32'h3, 1'b0, 1'b1);
    doRead(OFS_STATUS, 32'h2, "R9 program kept erase cleared");

    repeat (3) @(posedge clk);
    if (expQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL monitor: actual %0d pending expected 0", expQ.size());
    end
    finishRun();
  end
endmodule